// File: doc/BRIEF.md
# Switch-Selected Periodic Pulse Generator

This block runs from a 1 MHz reference clock, so each clock cycle is 1 µs. It emits a short pulse at one of four repetition rates: about 8 Hz, 80 Hz, 800 Hz or 8 kHz. Four one-hot switch lines choose the rate. The switch value first passes through a two-flop synchronizer. It is then decoded into a terminal count for a 17-bit up-counter.

The counter steps up by one while it is below the terminal count. Once it reaches or exceeds the terminal count, it returns to zero. A registered decode of the count gives a glitch-free pulse that lasts three cycles at the start of every period. The pulse appears one cycle after the matching count values. The current count is also brought out so that it can be observed.

Top module: `pulse_rate_gen`

## Requirements
- R1: A synchronous reset sets `count_o` to 0 and `pulse_o` to 0 at the clock edge where `rst_i` is high.
- R2: Selector 4'b0001 sets the terminal count to 124999, which gives a period of 125000 cycles.
- R3: Selector 4'b0010 sets the terminal count to 12499, which gives a period of 12500 cycles.
- R4: Selector 4'b0100 sets the terminal count to 1249, which gives a period of 1250 cycles.
- R5: Selector 4'b1000 sets the terminal count to 124, which gives a period of 125 cycles.
- R6: Any selector value other than the four one-hot codes gives a terminal count of 1. The count then alternates between 0 and 1, and `pulse_o` stays high without a break.
- R7: While the count is below the terminal count, it rises by exactly one per clock.
- R8: When the count equals or exceeds the terminal count, it becomes 0 at the next clock. This includes the case where the terminal count has just shrunk below the current count.
- R9: `pulse_o` is registered. At each edge it takes the value (count before that edge < 3). It is therefore high for exactly three consecutive cycles per period, starting one cycle after the count is 0.
- R10: A change on `sel_i` passes through two flops before it is decoded. The new terminal count first governs the third clock edge after the change. The change never resets the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 1 MHz reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 4 | One-hot rate switches, asynchronous |
| pulse_o | output | 1 | Registered three-cycle pulse |
| count_o | output | 17 | Current counter value |

## Verification
Each of the four one-hot codes is run for one full period from reset. The measured period and the peak count show whether the correct terminal value was decoded. An off-by-one in the wrap comparison also shows up as a wrong period. Several codes that are not one-hot (zero, two bits set, all bits set) confirm the fallback: the count alternates 0/1 and the pulse stays high, which sets that case apart from a mis-decoded slow rate. Two rate switches are made while the counter is running. A switch from slow to fast, made at a count well above the new terminal, checks that the counter recovers at once. A switch from fast to slower checks that counting continues without a reset. Both switches also show the two-cycle synchronizer latency.

// File: rtl/pulse_rate_gen.sv
module pulse_rate_gen #(
  parameter int CNT_W     = 17,
  parameter int SEL_W     = 4,
  parameter int TC_SLOW   = 124999,
  parameter int TC_MID    = 12499,
  parameter int TC_FAST   = 1249,
  parameter int TC_TOP    = 124,
  parameter int PULSE_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] TC_S = CNT_W'(TC_SLOW);
  localparam logic [CNT_W-1:0] TC_M = CNT_W'(TC_MID);
  localparam logic [CNT_W-1:0] TC_F = CNT_W'(TC_FAST);
  localparam logic [CNT_W-1:0] TC_T = CNT_W'(TC_TOP);
  localparam logic [CNT_W-1:0] TC_DFLT = CNT_W'(1);
  localparam logic [CNT_W-1:0] P_LEN = CNT_W'(PULSE_CYC);

  logic [SEL_W-1:0] sel_meta, sel_sync;
  logic [CNT_W-1:0] term, cnt;
  logic             pulse_q;

  always_ff @(posedge clk_i) begin
    sel_meta <= sel_i;
    sel_sync <= sel_meta;
  end

  always_comb begin
    case (sel_sync)
      4'b0001: term = TC_S;
      4'b0010: term = TC_M;
      4'b0100: term = TC_F;
      4'b1000: term = TC_T;
      default: term = TC_DFLT;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt     <= (cnt < term) ? cnt + 1'b1 : '0;
      pulse_q <= (cnt < P_LEN);
    end
  end

  assign pulse_o = pulse_q;
  assign count_o = cnt;

endmodule

// File: rtl/pulse_rate_gen_chk.sv
module pulse_rate_gen_chk #(
  parameter int CNT_W  = 17,
  parameter int MAX_TC = 124999,
  parameter int P_LEN  = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             pulse_o,
  input logic [CNT_W-1:0] count_o
);

  logic armed;
  always_ff @(posedge clk_i)
    if (rst_i) armed <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (count_o == '0 && !pulse_o)); // R1

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (count_o != '0) |-> (count_o == $past(count_o) + 1'b1)); // R7

  AST_ZERO_AFTER_TOP: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (count_o == '0) |-> ($past(count_o) != '0 || $past(rst_i))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    count_o <= CNT_W'(MAX_TC)); // R8

  AST_PULSE_LAG: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    !$past(rst_i) |-> (pulse_o == ($past(count_o) < CNT_W'(P_LEN)))); // R9

endmodule

bind pulse_rate_gen pulse_rate_gen_chk #(
  .CNT_W(CNT_W), .MAX_TC(TC_SLOW), .P_LEN(PULSE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .pulse_o(pulse_o), .count_o(count_o)
);

// File: tb/pulse_rate_gen_bench.sv
module pulse_rate_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sel = 4'b0000;
  logic        pulse;
  logic [16:0] cnt;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  pulse_rate_gen u_pulse_rate_gen (
    .clk_i(clk), .rst_i(rst), .sel_i(sel), .pulse_o(pulse), .count_o(cnt)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [3:0] s);
    rst = 1'b1;
    sel = s;
    tick(3);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    tick(2);
    chk(cnt == 0, "R1 count in reset", cnt, 0);
    chk(pulse == 1'b0, "R1 pulse in reset", pulse, 0);
  endtask

  task automatic t_period(input logic [3:0] s, input int term, input string tag);
    int high = 0;
    int low = 0;
    int peak = 0;
    int step_err = 0;
    int prev;
    restart(s);
    tick(1);
    prev = cnt;
    chk(pulse == 1'b1, "R9 pulse rises after reset", pulse, 1);
    while (pulse && high < 10) begin
      high++;
      tick(1);
      if (!(cnt == prev + 1 || (prev >= term && cnt == 0))) step_err++;
      prev = cnt;
    end
    chk(high == 3, "R9 pulse width", high, 3);
    while (!pulse && low < 130000) begin
      low++;
      if (int'(cnt) > peak) peak = cnt;
      tick(1);
      if (!(cnt == prev + 1 || (prev >= term && cnt == 0))) step_err++;
      prev = cnt;
    end
    chk(high + low == term + 1, {tag, " period"}, high + low, term + 1);
    chk(peak == term, {tag, " terminal count"}, peak, term);
    chk(step_err == 0, "R7 R8 count steps", step_err, 0);
  endtask

  task automatic t_fallback(input logic [3:0] s);
    int bad = 0;
    int prev;
    restart(s);
    tick(1);
    prev = cnt;
    for (int i = 0; i < 20; i++) begin
      if (!pulse || cnt > 1) bad++;
      tick(1);
      if (cnt == prev) bad++;
      prev = cnt;
    end
    chk(bad == 0, "R6 fallback divisor 1", bad, 0);
  endtask

  task automatic t_shrink();
    restart(4'b0001);
    tick(1000);
    chk(cnt == 1000, "R7 counting up", cnt, 1000);
    sel = 4'b1000;
    tick(2);
    chk(cnt == 1002, "R10 old divisor for two edges", cnt, 1002);
    tick(1);
    chk(cnt == 0, "R8 wrap after divisor shrink", cnt, 0);
    tick(1);
    chk(pulse == 1'b1, "R9 pulse after wrap", pulse, 1);
  endtask

  task automatic t_grow();
    int peak = 0;
    int guard = 0;
    restart(4'b1000);
    tick(10);
    sel = 4'b0100;
    tick(3);
    chk(cnt == 13, "R10 no counter reset on change", cnt, 13);
    while (cnt != 0 && guard < 2000) begin
      if (int'(cnt) > peak) peak = cnt;
      guard++;
      tick(1);
    end
    chk(peak == 1249, "R10 new divisor applied", peak, 1249);
  endtask

  task automatic t_midreset();
    restart(4'b0010);
    tick(50);
    rst = 1'b1;
    tick(1);
    chk(cnt == 0, "R1 mid-run reset count", cnt, 0);
    chk(pulse == 1'b0, "R1 mid-run reset pulse", pulse, 0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_period(4'b1000, 124, "R5");
    t_period(4'b0100, 1249, "R4");
    t_period(4'b0010, 12499, "R3");
    t_period(4'b0001, 124999, "R2");
    t_fallback(4'b0000);
    t_fallback(4'b0011);
    t_fallback(4'b1111);
    t_shrink();
    t_grow();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule